// File: doc/BRIEF.md
# Serial DAC Word Update Sequencer

This block sits on the host side of a serial-input digital-to-analog converter that has two ranks of latch. The converter's input register shifts on the rising edge of its strobe pin, and a separate load line copies that register into the output rank. When the host pulses a start request with a 16-bit sample, the sequencer first pulls the load line low. It then sends the sample on a data line, most significant bit first, as two bursts of eight strobe pulses. The strobe idles low, and each data bit is placed on the line a full half period before the rising edge that samples it. After the sixteenth bit the strobe returns low and the load line rises. The whole word then reaches the converter output in one step.

The strobe timing comes from the system clock through parameters. `HALF_CYC` sets the number of clock cycles in each strobe phase, `GAP_CYC` sets the idle low time between the two bursts, and `LOAD_MIN` sets the shortest high time of the load line between frames. The host sees a start/busy/done handshake. A start request is taken only while the sequencer is idle.

The controller has seven states. IDLE waits for start. ARM holds the load line high until it has recovered from the previous frame. LEAD drops the load line and presents the first bit. HIGH drives the strobe high. LOW presents the next bit inside a burst. GAP is the longer low time between the bursts. TAIL keeps the strobe low before the load line rises. The transitions are:
- IDLE→ARM on an accepted start.
- ARM→LEAD once recovery is met.
- LEAD→HIGH, LOW→HIGH and GAP→HIGH when their phase timer expires.
- HIGH→LOW inside a burst, HIGH→GAP after bit 8, and HIGH→TAIL after bit 16.
- TAIL→IDLE, with the load line rising and done pulsing.

Top module: `dacser_seq`

## Requirements
- R1: While reset is held and in the first idle cycle after it, the outputs are: load line high, strobe low, data 0, busy 0, done 0.
- R2: The load line falls before the first rising strobe edge of a frame and stays low throughout the frame; the strobe is never high while the load line is high.
- R3: Each frame has exactly 16 rising strobe edges, grouped as two bursts of 8. Between the 8th and 9th edges the strobe stays low for at least `GAP_CYC` clock cycles.
- R4: The data bit sampled at the k-th rising edge (k = 0..15) is bit 15−k of the accepted word. The high byte goes first, then the low byte, and a receiver that shifts in on each rising edge ends up holding the accepted word.
- R5: Each strobe high phase and low phase lasts at least `HALF_CYC` cycles, and at least 30 ns; a full period lasts at least 80 ns. Data is stable for at least `HALF_CYC` cycles, and at least 40 ns, before each rising edge, and does not change in the cycle of that edge.
- R6: The load line rises only after the 16th rising edge, once the strobe has been low again for at least `HALF_CYC` cycles.
- R7: Between frames the load line stays high for at least `LOAD_MIN` cycles, and at least 40 ns, even when a new start arrives right after done.
- R8: Busy goes high in the cycle after a start is accepted and falls in the same cycle the load line rises. Done is high for exactly that one cycle.
- R9: A start request made while busy is ignored. The frame in progress completes unchanged, and no extra frame follows.
- R10: The word is captured when the start is accepted. Changes on the word input during a frame do not affect the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one word update (taken only when idle) |
| word_i | input | WORD_W | Sample to send, captured with an accepted start |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the load line rises |
| sclk_o | output | 1 | Shift strobe to the converter, idles low, samples on rise |
| sdata_o | output | 1 | Serial data, MSB first |
| load_o | output | 1 | Load line: low during the frame, rises to update the output |

## Verification
The test words are all zeros, all ones, a lone MSB, its complement, words with only the high or only the low byte set, an alternating pattern, and a run of random words.

The uniform words check the edge count and framing without any help from data transitions. The one-byte words show whether the two bytes come out in the right order. The lone MSB, its complement and the alternating pattern expose a bit-order reversal or an off-by-one shift.

Back-to-back frames test the recovery time of the load line. A second start, together with a changed word, injected in the middle of a frame shows that requests are ignored while busy and that the word was captured at the accepted start.

// File: rtl/dacser_pkg.sv
package dacser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_GAP,
        ST_TAIL
    } seq_state_e;

    // Load line is low in every state that belongs to an open frame.
    function automatic logic in_frame(input seq_state_e s);
        return (s == ST_LEAD) || (s == ST_HIGH) || (s == ST_LOW) ||
               (s == ST_GAP)  || (s == ST_TAIL);
    endfunction

endpackage

// File: rtl/dacser_timer.sv
module dacser_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] len,
    output logic          expire
);

    logic [TW-1:0] cnt_q;

    // Loaded with len-1 on entry to a phase, so the phase lasts len cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= len - TW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/dacser_shreg.sv
module dacser_shreg #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int LANE_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] din,
    input  logic              shift,
    output logic              msb,
    output logic              last_bit,
    output logic              byte_end
);

    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] sh_d;
    logic [BIT_W-1:0]  bit_q;

    // One cell per bit: load, shift toward the MSB, or hold.
    for (genvar g = 0; g < WORD_W; g++) begin : g_cell
        if (g == 0) begin : g_lsb
            assign sh_d[g] = capture ? din[g] : (shift ? 1'b0 : sh_q[g]);
        end else begin : g_mid
            assign sh_d[g] = capture ? din[g] : (shift ? sh_q[g-1] : sh_q[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= '0;
        end else begin
            sh_q <= sh_d;
            if (capture) begin
                bit_q <= '0;
            end else if (shift) begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end
    end

    assign msb      = sh_q[WORD_W-1];
    assign last_bit = (bit_q == BIT_W'(WORD_W - 1));
    assign byte_end = &bit_q[LANE_W-1:0];

endmodule

// File: rtl/dacser_recov.sv
module dacser_recov #(
    parameter int LOAD_MIN = 5,
    localparam int RW = $clog2(LOAD_MIN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_hi,
    output logic ready
);

    logic [RW-1:0] cnt_q;

    // Counts cycles the load line has been high; a reset counts as recovered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RW'(LOAD_MIN);
        end else if (!line_hi) begin
            cnt_q <= '0;
        end else if (cnt_q < RW'(LOAD_MIN)) begin
            cnt_q <= cnt_q + RW'(1);
        end
    end

    assign ready = (cnt_q >= RW'(LOAD_MIN));

endmodule

// File: rtl/dacser_seq.sv
module dacser_seq
    import dacser_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int BYTE_W   = 8,
    parameter int HALF_CYC = 5,
    parameter int GAP_CYC  = 10,
    parameter int LOAD_MIN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              load_o
);

    localparam int TMAX = (GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_e    state_q, state_d;
    logic          tmr_exp;
    logic          tmr_restart;
    logic [TW-1:0] tmr_len;
    logic          take;
    logic          shift;
    logic          last_bit;
    logic          byte_end;
    logic          rec_ready;

    assign take  = start_i && (state_q == ST_IDLE);
    assign shift = (state_q == ST_HIGH) && tmr_exp;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_ARM;
            ST_ARM:  if (rec_ready) state_d = ST_LEAD;
            ST_LEAD: if (tmr_exp)   state_d = ST_HIGH;
            ST_HIGH: begin
                if (tmr_exp) begin
                    if (last_bit)      state_d = ST_TAIL;
                    else if (byte_end) state_d = ST_GAP;
                    else               state_d = ST_LOW;
                end
            end
            ST_LOW:  if (tmr_exp)   state_d = ST_HIGH;
            ST_GAP:  if (tmr_exp)   state_d = ST_HIGH;
            ST_TAIL: if (tmr_exp)   state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    assign tmr_restart = (state_d != state_q);
    assign tmr_len     = (state_d == ST_GAP) ? TW'(GAP_CYC) : TW'(HALF_CYC);

    // Registered outputs decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_o <= 1'b1;
            sclk_o <= 1'b0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            load_o <= !in_frame(state_d);
            sclk_o <= (state_d == ST_HIGH);
            busy_o <= (state_d != ST_IDLE);
            done_o <= (state_q == ST_TAIL) && (state_d == ST_IDLE);
        end
    end

    dacser_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .len     (tmr_len),
        .expire  (tmr_exp)
    );

    dacser_shreg #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (take),
        .din      (word_i),
        .shift    (shift),
        .msb      (sdata_o),
        .last_bit (last_bit),
        .byte_end (byte_end)
    );

    dacser_recov #(.LOAD_MIN(LOAD_MIN)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_hi (load_o),
        .ready   (rec_ready)
    );

endmodule

// File: rtl/dacser_seq_chk.sv
module dacser_seq_chk #(
    parameter int WORD_W   = 16,
    parameter int HALF_CYC = 5,
    parameter int LOAD_MIN = 5,
    parameter int CLK_PS   = 8000
) (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic sclk_o,
    input logic sdata_o,
    input logic load_o
);

    localparam logic [15:0] SAT = 16'hFFFF;

    logic        sclk_last, dat_last, ld_last;
    logic [15:0] s_run, hi_len, d_run, l_run;
    logic [7:0]  edges;
    logic        rise, fall;

    assign rise = sclk_o && !sclk_last;
    assign fall = !sclk_o && sclk_last;

    // Each run counter holds the number of cycles the previous value was held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_last <= 1'b0;
            dat_last  <= 1'b0;
            ld_last   <= 1'b1;
            s_run     <= SAT;
            hi_len    <= SAT;
            d_run     <= SAT;
            l_run     <= SAT;
            edges     <= '0;
        end else begin
            sclk_last <= sclk_o;
            dat_last  <= sdata_o;
            ld_last   <= load_o;
            s_run <= (sclk_o != sclk_last) ? 16'd1 : ((s_run != SAT) ? s_run + 16'd1 : s_run);
            d_run <= (sdata_o != dat_last) ? 16'd1 : ((d_run != SAT) ? d_run + 16'd1 : d_run);
            l_run <= (load_o != ld_last)   ? 16'd1 : ((l_run != SAT) ? l_run + 16'd1 : l_run);
            if (fall) hi_len <= s_run;
            if (!load_o && ld_last) edges <= '0;
            else if (rise) edges <= edges + 8'd1;
        end
    end

    a_r5_low_time: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (int'(s_run) >= HALF_CYC && int'(s_run) * CLK_PS >= 30000));

    a_r5_high_time: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (int'(s_run) >= HALF_CYC && int'(s_run) * CLK_PS >= 30000));

    a_r5_period: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> ((int'(s_run) + int'(hi_len)) * CLK_PS >= 80000));

    a_r5_setup: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (int'(d_run) >= HALF_CYC && int'(d_run) * CLK_PS >= 40000));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (sdata_o == dat_last));

    a_r2_strobe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !load_o);

    a_r3_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && !ld_last) |-> (int'(edges) == WORD_W));

    a_r6_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && !ld_last) |-> (!sclk_o && int'(s_run) >= HALF_CYC));

    a_r7_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_o && ld_last) |-> (int'(l_run) >= LOAD_MIN && int'(l_run) * CLK_PS >= 40000));

    a_r8_done_at_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && !ld_last) |-> done_o);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (load_o && !busy_o));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_busy_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |-> busy_o);

endmodule

bind dacser_seq dacser_seq_chk #(
    .WORD_W   (WORD_W),
    .HALF_CYC (HALF_CYC),
    .LOAD_MIN (LOAD_MIN),
    .CLK_PS   (8000)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .load_o  (load_o)
);

// File: tb/dacser_seq_tb.sv
module dacser_seq_tb_top;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int HALF_CYC = 5;
    localparam int GAP_CYC  = 10;
    localparam int LOAD_MIN = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [WORD_W-1:0] word_i = '0;
    logic              busy_o, done_o, sclk_o, sdata_o, load_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dacser_seq #(
        .WORD_W(WORD_W), .BYTE_W(BYTE_W), .HALF_CYC(HALF_CYC),
        .GAP_CYC(GAP_CYC), .LOAD_MIN(LOAD_MIN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
        .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o),
        .sdata_o(sdata_o), .load_o(load_o)
    );

    // Behavioural converter: input rank shifts on strobe rise, output rank on load rise.
    logic [WORD_W-1:0] rx_sh = '0;
    logic [WORD_W-1:0] rx_out = '0;
    int                rx_edges = 0;

    always @(posedge sclk_o) begin
        rx_sh    = {rx_sh[WORD_W-2:0], sdata_o};
        rx_edges = rx_edges + 1;
    end
    always @(negedge load_o) rx_edges = 0;
    always @(posedge load_o) rx_out = rx_sh;

    // Timing monitor sampled away from the active edge
    logic p_sclk = 1'b0, p_load = 1'b1;
    int s_run = 1000, l_run = 1000;
    int f_minlo = 1000, f_minhi = 1000, f_gap = 0, f_rises = 0, f_viol = 0, f_done = 0;
    int r_minlo = 0, r_minhi = 0, r_gap = 0, r_viol = 0, r_done = 0, r_tail = 0;
    int l_hi_last = 1000;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) f_done = f_done + 1;
            if (sclk_o && load_o) f_viol = f_viol + 1;
            if (sclk_o != p_sclk) begin
                if (sclk_o) begin
                    if (s_run < f_minlo) f_minlo = s_run;
                    if (f_rises == BYTE_W) f_gap = s_run;
                    f_rises = f_rises + 1;
                end else if (s_run < f_minhi) begin
                    f_minhi = s_run;
                end
                s_run = 1;
            end else begin
                s_run = s_run + 1;
            end
            if (load_o != p_load) begin
                if (!load_o) begin
                    l_hi_last = l_run;
                    f_minlo = 1000; f_minhi = 1000; f_gap = 0;
                    f_rises = 0; f_viol = 0; f_done = 0;
                end else begin
                    r_tail = sclk_o ? 0 : s_run;
                    r_minlo = f_minlo; r_minhi = f_minhi; r_gap = f_gap;
                    r_viol = f_viol; r_done = f_done;
                end
                l_run = 1;
            end else begin
                l_run = l_run + 1;
            end
            p_sclk = sclk_o;
            p_load = load_o;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [WORD_W-1:0] w, input bit poke);
        @(negedge clk);
        start_i = 1'b1;
        word_i  = w;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R8", "busy after start", int'(busy_o), 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            start_i = 1'b1;
            word_i  = ~w;
            @(negedge clk);
            start_i = 1'b0;
            word_i  = w ^ 16'h5A5A;
        end
        while (!done_o) @(negedge clk);
        check(load_o && !busy_o, "R8", "load high and busy low with done",
              {30'd0, load_o, busy_o}, 2);
        @(negedge clk);
        check(!done_o && r_done == 1, "R8", "done width", r_done, 1);
        check(rx_out == w, poke ? "R10" : "R4", "received word", int'(rx_out), int'(w));
        check(rx_edges == WORD_W, "R3", "rising edges", rx_edges, WORD_W);
        check(r_gap >= GAP_CYC, "R3", "byte gap", r_gap, GAP_CYC);
        check(r_minlo >= HALF_CYC && r_minhi >= HALF_CYC, "R5", "min phase",
              (r_minlo < r_minhi) ? r_minlo : r_minhi, HALF_CYC);
        check(r_viol == 0, "R2", "strobe high while load high", r_viol, 0);
        check(r_tail >= HALF_CYC, "R6", "strobe low before load rise", r_tail, HALF_CYC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks = checks + 1;
        fails  = fails + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        logic [WORD_W-1:0] rw;
        seed_v = $urandom(32'd20240);
        repeat (4) @(negedge clk);
        check(load_o && !sclk_o && !sdata_o && !busy_o && !done_o, "R1",
              "outputs in reset", {27'd0, load_o, sclk_o, sdata_o, busy_o, done_o}, 16);
        rst_n = 1'b1;
        @(negedge clk);
        check(load_o && !sclk_o && !sdata_o && !busy_o && !done_o, "R1",
              "outputs after reset", {27'd0, load_o, sclk_o, sdata_o, busy_o, done_o}, 16);

        // Directed corner words
        send(16'h0000, 1'b0);
        send(16'hFFFF, 1'b0);
        send(16'h8000, 1'b0);
        send(16'h7FFF, 1'b0);
        send(16'hFF00, 1'b0);
        send(16'h00FF, 1'b0);
        send(16'hA5C3, 1'b0);

        // R7: back-to-back start right after done
        send(16'h1234, 1'b0);
        send(16'hEDCB, 1'b0);
        check(l_hi_last >= LOAD_MIN, "R7", "load high between frames", l_hi_last, LOAD_MIN);

        // R9 / R10: start and word changes during a frame
        repeat (20) @(negedge clk);
        send(16'hC3A5, 1'b1);
        repeat (60) @(negedge clk);
        check(load_o && !busy_o && rx_edges == WORD_W, "R9", "no extra frame",
              rx_edges, WORD_W);
        check(rx_out == 16'hC3A5, "R9", "word after ignored start", int'(rx_out), 'hC3A5);

        // Random words
        for (int i = 0; i < 20; i++) begin
            rw = WORD_W'($urandom);
            repeat ($urandom_range(0, 12)) @(negedge clk);
            send(rw, (i % 5) == 2);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule